// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer core of a small processor in which every internal move crosses one shared bus. It holds a bank of general registers, a program counter, an instruction register, a memory address register, a memory data register, an operand latch in front of the ALU and a result latch behind it, plus a two-flag condition-code register. An external controller asserts a set of strobes each cycle. The "out" strobes choose the single source that drives the bus. The "in" strobes choose every register that captures the bus at the next rising edge.

Because there is only one bus, an ALU operation is spread over several cycles. The first operand is parked in the operand latch, or replaced by the constant 4 for program-counter stepping. The second operand is whatever drives the bus in the operate cycle. The result waits in the result latch until a later cycle puts it on the bus. The memory side is a request/complete handshake. The address register drives the address lines. A read or write request stays raised until the memory signals completion, and a read completion writes the returned data into the data register.

Top module: `sbdp_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter, all registers, both flags and any pending memory request.
- R2: `bus_value` equals the register selected by the single asserted out strobe, or zero when none is asserted. The address-field strobe drives the low ADDR_FIELD_W bits of the instruction register, with the upper bits zero.
- R3: Every register whose in strobe is set takes the bus value at the rising edge, and several registers may load in the same cycle.
- R4: The ALU's first operand is the operand latch when `sel_y`=1 and the constant 4 when `sel_y`=0. The second operand is the bus. `alu_op`=00 adds the two and `alu_op`=01 subtracts the second from the first, both modulo 2^DATA_W.
- R5: `alu_op`=10 gives bus+1 and `alu_op`=11 gives bus-1, both modulo 2^DATA_W, so the count wraps at zero and at the all-ones value.
- R6: The result latch changes only at an edge where `z_in` is set. Its value reaches the bus only in a later cycle, under `z_out`.
- R7: When `flag_upd` is set, `cc_n` takes the ALU result's top bit and `cc_z` takes whether the result is zero. Otherwise both flags hold their value.
- R8: `mem_addr` shows the address register. After a `mem_read` strobe, `mem_rd` is high from the next cycle until the cycle in which `mem_mfc` is seen, and at that edge the data register takes `mem_rdata`.
- R9: After a `mem_write` strobe, `mem_wr` is high until `mem_mfc` is seen, with `mem_wdata` showing the data register. A read strobe in the same cycle wins over a write strobe.
- R10: `mem_mfc` with no request pending has no effect on the data register or on `mem_rd` and `mem_wr`.
- R11: `mdr_in` loads the data register from the bus. If a read completes in the same cycle, the memory data wins.
- R12: The three-step sequence (first source out with `y_in`; second source out with `sel_y`, add and `z_in`; `z_out` with the destination's in strobe) leaves the sum in the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_out | input | 1 | Program counter drives bus |
| mdr_out | input | 1 | Data register drives bus |
| z_out | input | 1 | Result latch drives bus |
| ir_addr_out | input | 1 | Instruction address field drives bus |
| reg_out | input | NREG | One-hot general register driver select |
| pc_in | input | 1 | Program counter loads bus |
| ir_in | input | 1 | Instruction register loads bus |
| mar_in | input | 1 | Address register loads bus |
| mdr_in | input | 1 | Data register loads bus |
| y_in | input | 1 | Operand latch loads bus |
| z_in | input | 1 | Result latch loads ALU output |
| reg_in | input | NREG | General register load enables |
| sel_y | input | 1 | First ALU operand: 1 latch, 0 constant 4 |
| alu_op | input | 2 | 00 add, 01 sub, 10 inc, 11 dec |
| flag_upd | input | 1 | Capture N and Z flags |
| mem_read | input | 1 | Start a memory read |
| mem_write | input | 1 | Start a memory write |
| mem_mfc | input | 1 | Memory function complete |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_addr | output | DATA_W | Address register contents |
| mem_wdata | output | DATA_W | Data register contents |
| mem_rd | output | 1 | Read request pending |
| mem_wr | output | 1 | Write request pending |
| bus_value | output | DATA_W | Internal bus value |
| ir_word | output | DATA_W | Instruction register for decode |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |

## Verification
The assertions assume that the controller never raises two out strobes in one cycle. The bench drives one driver at a time from tasks that clear every strobe after each edge, so the bus is never contended. The assertions also assume that completion is signalled only while a request is outstanding, unless that case is being tested, and that a new request is not issued in the completion cycle. The bench keeps to both assumptions, except in one deliberate stray-completion test that checks R10. Operands enter only through memory reads, so every ALU sweep point first passes through the completion path.

// File: rtl/sbdp_pkg.sv
package sbdp_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_INC = 2'b10,
        ALU_DEC = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        MEM_IDLE = 2'b00,
        MEM_RD   = 2'b01,
        MEM_WR   = 2'b10
    } mem_state_e;

    localparam int STEP_CONST = 4;

    // number of fixed bus sources ahead of the general registers
    localparam int FIXED_SRCS = 4;

    function automatic int src_count(input int nreg);
        return FIXED_SRCS + nreg;
    endfunction

endpackage

// File: rtl/sbdp_bus_mux.sv
module sbdp_bus_mux #(
    parameter int W    = 32,
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0]        sel,
    input  logic [NSRC-1:0][W-1:0] src,
    output logic [W-1:0]           bus
);
    // AND-OR tree: one-hot select, zero when idle
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            bus = bus | (src[i] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/sbdp_alu.sv
module sbdp_alu
    import sbdp_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic         sel_y,
    input  logic [W-1:0] y_val,
    input  logic [W-1:0] b_val,
    output logic [W-1:0] res,
    output logic         neg,
    output logic         zero
);
    localparam logic [W-1:0] STEP = W'(STEP_CONST);
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] a_val;

    assign a_val = sel_y ? y_val : STEP;

    always_comb begin
        unique case (op)
            ALU_ADD: res = a_val + b_val;
            ALU_SUB: res = a_val - b_val;
            ALU_INC: res = b_val + ONE;
            ALU_DEC: res = b_val - ONE;
            default: res = '0;
        endcase
    end

    assign neg  = res[W-1];
    assign zero = (res == '0);
endmodule

// File: rtl/sbdp_regfile.sv
module sbdp_regfile #(
    parameter int W    = 32,
    parameter int NREG = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NREG-1:0]        wr_en,
    input  logic [W-1:0]           din,
    output logic [NREG-1:0][W-1:0] q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (wr_en[g]) begin
                q[g] <= din;
            end
        end
    end
endmodule

// File: rtl/sbdp_mem_port.sv
module sbdp_mem_port
    import sbdp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    input  logic mfc,
    output logic rd_pend,
    output logic wr_pend,
    output logic rd_done
);
    mem_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MEM_IDLE;
        end else if (rd_req) begin
            state_q <= MEM_RD;
        end else if (wr_req) begin
            state_q <= MEM_WR;
        end else if (mfc) begin
            state_q <= MEM_IDLE;
        end
    end

    assign rd_pend = (state_q == MEM_RD);
    assign wr_pend = (state_q == MEM_WR);
    assign rd_done = rd_pend && mfc;
endmodule

// File: rtl/sbdp_datapath.sv
module sbdp_datapath
    import sbdp_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int NREG         = 4,
    parameter int ADDR_FIELD_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_out,
    input  logic              mdr_out,
    input  logic              z_out,
    input  logic              ir_addr_out,
    input  logic [NREG-1:0]   reg_out,
    input  logic              pc_in,
    input  logic              ir_in,
    input  logic              mar_in,
    input  logic              mdr_in,
    input  logic              y_in,
    input  logic              z_in,
    input  logic [NREG-1:0]   reg_in,
    input  logic              sel_y,
    input  logic [1:0]        alu_op,
    input  logic              flag_upd,
    input  logic              mem_read,
    input  logic              mem_write,
    input  logic              mem_mfc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] bus_value,
    output logic [DATA_W-1:0] ir_word,
    output logic              cc_n,
    output logic              cc_z
);
    localparam int NSRC = src_count(NREG);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        (ADDR_FIELD_W >= DATA_W) ? {DATA_W{1'b1}}
                                 : ((DATA_W'(1) << ADDR_FIELD_W) - DATA_W'(1));

    logic [DATA_W-1:0] pc_q, ir_q, mar_q, mdr_q, y_q, z_q;
    logic [DATA_W-1:0] bus_w, alu_res;
    logic              alu_neg, alu_zero, rd_done;
    logic [NREG-1:0][DATA_W-1:0] gpr_q;
    logic [NSRC-1:0][DATA_W-1:0] src_w;
    logic [NSRC-1:0]             sel_w;

    always_comb begin
        src_w[0] = pc_q;
        src_w[1] = mdr_q;
        src_w[2] = z_q;
        src_w[3] = ir_q & FIELD_MASK;
        for (int i = 0; i < NREG; i++) begin
            src_w[FIXED_SRCS+i] = gpr_q[i];
        end
        sel_w = {reg_out, ir_addr_out, z_out, mdr_out, pc_out};
    end

    sbdp_bus_mux #(.W(DATA_W), .NSRC(NSRC)) u_mux (
        .sel (sel_w),
        .src (src_w),
        .bus (bus_w)
    );

    sbdp_alu #(.W(DATA_W)) u_alu (
        .op    (alu_op_e'(alu_op)),
        .sel_y (sel_y),
        .y_val (y_q),
        .b_val (bus_w),
        .res   (alu_res),
        .neg   (alu_neg),
        .zero  (alu_zero)
    );

    sbdp_regfile #(.W(DATA_W), .NREG(NREG)) u_gpr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_in),
        .din   (bus_w),
        .q     (gpr_q)
    );

    sbdp_mem_port u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (mem_read),
        .wr_req  (mem_write),
        .mfc     (mem_mfc),
        .rd_pend (mem_rd),
        .wr_pend (mem_wr),
        .rd_done (rd_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mar_q <= '0;
            y_q   <= '0;
            z_q   <= '0;
            cc_n  <= 1'b0;
            cc_z  <= 1'b0;
        end else begin
            if (pc_in)  pc_q  <= bus_w;
            if (ir_in)  ir_q  <= bus_w;
            if (mar_in) mar_q <= bus_w;
            if (y_in)   y_q   <= bus_w;
            if (z_in)   z_q   <= alu_res;
            if (flag_upd) begin
                cc_n <= alu_neg;
                cc_z <= alu_zero;
            end
        end
    end

    // data register: memory completion outranks the bus path
    always_ff @(posedge clk) begin
        if (rst) begin
            mdr_q <= '0;
        end else if (rd_done) begin
            mdr_q <= mem_rdata;
        end else if (mdr_in) begin
            mdr_q <= bus_w;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign bus_value = bus_w;
    assign ir_word   = ir_q;
endmodule

// File: rtl/sbdp_checker.sv
module sbdp_checker #(
    parameter int W    = 32,
    parameter int NDRV = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [NDRV-1:0] drv,
    input logic [W-1:0]    bus,
    input logic [W-1:0]    pc_q,
    input logic [W-1:0]    z_q,
    input logic [W-1:0]    mdr_q,
    input logic            pc_in,
    input logic            z_in,
    input logic            mdr_in,
    input logic            flag_upd,
    input logic            cc_n,
    input logic            cc_z,
    input logic            mem_read,
    input logic            mem_write,
    input logic            mem_mfc,
    input logic [W-1:0]    mem_rdata,
    input logic            mem_rd,
    input logic            mem_wr
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && z_q == '0 && mdr_q == '0 && !mem_rd && !mem_wr && !cc_n && !cc_z));

    // R2
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv));

    // R3
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        pc_in |=> pc_q == $past(bus));

    // R6
    z_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !z_in |=> $stable(z_q));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_upd |=> ($stable(cc_n) && $stable(cc_z)));

    // R8
    read_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_mfc && !mem_read && !mem_write) |=> !mem_rd);

    // R8
    read_data_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_mfc) |=> mdr_q == $past(mem_rdata));

    // R9
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_mfc && !mem_read) |=> mem_wr);

    // R10
    mdr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd && !mdr_in) |=> $stable(mdr_q));
endmodule

bind sbdp_datapath sbdp_checker #(.W(DATA_W), .NDRV(NREG + 4)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .drv       ({reg_out, ir_addr_out, z_out, mdr_out, pc_out}),
    .bus       (bus_w),
    .pc_q      (pc_q),
    .z_q       (z_q),
    .mdr_q     (mdr_q),
    .pc_in     (pc_in),
    .z_in      (z_in),
    .mdr_in    (mdr_in),
    .flag_upd  (flag_upd),
    .cc_n      (cc_n),
    .cc_z      (cc_z),
    .mem_read  (mem_read),
    .mem_write (mem_write),
    .mem_mfc   (mem_mfc),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/tb_sbdp_datapath.sv
`timescale 1ns/1ps
module tb_sbdp_datapath;
    localparam int W  = 8;
    localparam int NR = 4;
    localparam int AF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_out, mdr_out, z_out, ir_addr_out, pc_in, ir_in, mar_in, mdr_in;
    logic y_in, z_in, sel_y, flag_upd, mem_read, mem_write, mem_mfc;
    logic [NR-1:0] reg_out, reg_in;
    logic [1:0]    alu_op;
    logic [W-1:0]  mem_rdata, mem_addr, mem_wdata, bus_value, ir_word;
    logic          mem_rd, mem_wr, cc_n, cc_z;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sbdp_datapath #(.DATA_W(W), .NREG(NR), .ADDR_FIELD_W(AF)) dut (
        .clk(clk), .rst(rst), .pc_out(pc_out), .mdr_out(mdr_out), .z_out(z_out),
        .ir_addr_out(ir_addr_out), .reg_out(reg_out), .pc_in(pc_in), .ir_in(ir_in),
        .mar_in(mar_in), .mdr_in(mdr_in), .y_in(y_in), .z_in(z_in), .reg_in(reg_in),
        .sel_y(sel_y), .alu_op(alu_op), .flag_upd(flag_upd), .mem_read(mem_read),
        .mem_write(mem_write), .mem_mfc(mem_mfc), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .bus_value(bus_value), .ir_word(ir_word), .cc_n(cc_n), .cc_z(cc_z)
    );

    task automatic idle();
        pc_out = 0; mdr_out = 0; z_out = 0; ir_addr_out = 0; reg_out = '0;
        pc_in = 0; ir_in = 0; mar_in = 0; mdr_in = 0; y_in = 0; z_in = 0;
        reg_in = '0; sel_y = 0; alu_op = 2'b00; flag_upd = 0;
        mem_read = 0; mem_write = 0; mem_mfc = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic mem_load(input logic [W-1:0] v);
        mem_read = 1; tick();
        mem_mfc = 1; mem_rdata = v; tick();
    endtask

    function automatic logic [W-1:0] model(input logic [1:0] op,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
        int r;
        case (op)
            2'b00:   r = int'(a) + int'(b);
            2'b01:   r = int'(a) - int'(b);
            2'b10:   r = int'(b) + 1;
            default: r = int'(b) - 1;
        endcase
        return W'(r & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        mem_rdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state, R2 idle bus reads zero
        chk("R2 idle bus", bus_value, 0);
        pc_out = 1; #1; chk("R1 pc", bus_value, 0); idle();
        chk("R1 mem_rd", mem_rd, 0);
        chk("R1 mem_wr", mem_wr, 0);
        chk("R1 flags", {cc_n, cc_z}, 0);

        // R3 several loaders from one driver
        mem_load(8'hA5);
        mdr_out = 1; reg_in = 4'b0101; pc_in = 1; tick();
        reg_out = 4'b0001; #1; chk("R3 r0", bus_value, 8'hA5); idle();
        reg_out = 4'b0100; #1; chk("R3 r2", bus_value, 8'hA5); idle();
        pc_out = 1; #1; chk("R3 pc", bus_value, 8'hA5); idle();

        // R12 three-step add
        mem_load(8'h3C); mdr_out = 1; reg_in = 4'b0010; tick();
        mem_load(8'h21); mdr_out = 1; reg_in = 4'b0100; tick();
        reg_out = 4'b0010; y_in = 1; tick();
        reg_out = 4'b0100; sel_y = 1; alu_op = 2'b00; z_in = 1; tick();
        z_out = 1; reg_in = 4'b0100; tick();
        reg_out = 4'b0100; #1; chk("R12 sum", bus_value, 8'h5D); idle();

        // R4 program counter step by constant
        pc_out = 1; sel_y = 0; alu_op = 2'b00; z_in = 1; tick();
        z_out = 1; pc_in = 1; tick();
        pc_out = 1; #1; chk("R4 pc+4", bus_value, 8'hA9); idle();

        // R6 result latch holds without z_in
        pc_out = 1; sel_y = 0; alu_op = 2'b01; tick();
        z_out = 1; #1; chk("R6 z hold", bus_value, 8'hA9); idle();

        // R2 address field of the instruction register
        mem_load(8'hF3); mdr_out = 1; ir_in = 1; tick();
        chk("R2 ir word", ir_word, 8'hF3);
        ir_addr_out = 1; #1; chk("R2 addr field", bus_value, 8'h13); idle();

        // R8 read handshake held until completion
        ir_addr_out = 1; mar_in = 1; mem_read = 1; tick();
        chk("R8 addr", mem_addr, 8'h13);
        chk("R8 rd high", mem_rd, 1);
        tick(); tick();
        chk("R8 rd held", mem_rd, 1);
        mdr_out = 1; #1; chk("R8 mdr unchanged", bus_value, 8'hF3); idle();
        mem_mfc = 1; mem_rdata = 8'h6E; tick();
        chk("R8 rd drop", mem_rd, 0);
        mdr_out = 1; #1; chk("R8 mdr data", bus_value, 8'h6E); idle();

        // R10 stray completion ignored
        mem_mfc = 1; mem_rdata = 8'h11; tick();
        mdr_out = 1; #1; chk("R10 mdr", bus_value, 8'h6E); idle();
        chk("R10 no req", {mem_rd, mem_wr}, 0);

        // R11 bus load, then memory wins over bus
        reg_out = 4'b0001; mdr_in = 1; tick();
        mdr_out = 1; #1; chk("R11 bus load", bus_value, 8'hA5); idle();
        mem_read = 1; tick();
        mem_mfc = 1; mem_rdata = 8'h42; reg_out = 4'b0001; mdr_in = 1; tick();
        mdr_out = 1; #1; chk("R11 priority", bus_value, 8'h42); idle();

        // R9 write handshake, and read priority
        mem_write = 1; tick();
        chk("R9 wr high", mem_wr, 1);
        chk("R9 wdata", mem_wdata, 8'h42);
        tick();
        chk("R9 wr held", mem_wr, 1);
        mem_mfc = 1; tick();
        chk("R9 wr drop", mem_wr, 0);
        mem_read = 1; mem_write = 1; tick();
        chk("R9 read wins", {mem_rd, mem_wr}, 2'b10);
        mem_mfc = 1; mem_rdata = 8'h42; tick();

        // R7 flags hold without flag_upd
        mem_load(8'h80); mdr_out = 1; alu_op = 2'b10; flag_upd = 1; tick();
        chk("R7 set", {cc_n, cc_z}, 2'b10);
        mem_load(8'hFF); mdr_out = 1; alu_op = 2'b10; z_in = 1; tick();
        chk("R7 hold", {cc_n, cc_z}, 2'b10);
        z_out = 1; #1; chk("R5 inc wrap", bus_value, 8'h00); idle();

        // R4 constant operand sweep over every bus value
        for (int b = 0; b < 256; b++) begin
            mem_load(W'(b));
            mdr_out = 1; sel_y = 0; alu_op = b[0] ? 2'b01 : 2'b00; z_in = 1; tick();
            z_out = 1; #1;
            chk("R4 const", bus_value, model(b[0] ? 2'b01 : 2'b00, 8'd4, W'(b)));
            idle();
        end

        // R4 R5 R7 operand sweep, all four operations
        for (int a = 0; a < 256; a += 5) begin
            for (int b = 0; b < 256; b += 5) begin
                mem_load(W'(a));
                mdr_out = 1; y_in = 1; mem_read = 1; tick();
                mem_mfc = 1; mem_rdata = W'(b); tick();
                for (int op = 0; op < 4; op++) begin
                    logic [W-1:0] e;
                    e = model(2'(op), W'(a), W'(b));
                    mdr_out = 1; sel_y = 1; alu_op = 2'(op); z_in = 1; flag_upd = 1; tick();
                    z_out = 1; #1;
                    chk(op < 2 ? "R4 sweep" : "R5 sweep", bus_value, e);
                    chk("R7 flags", {cc_n, cc_z}, {e[W-1], e == 0});
                    idle();
                end
            end
        end

        // R5 decrement wraps at zero
        mem_load(8'h00); mdr_out = 1; alu_op = 2'b11; z_in = 1; tick();
        z_out = 1; #1; chk("R5 dec wrap", bus_value, 8'hFF); idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule